// File: doc/BRIEF.md
# Interlaced Video Field Detector

This block tells the two fields of an interlaced picture apart. It measures where the vertical sync leading edge lands inside the current horizontal line. A line-phase counter restarts at every horizontal sync rising edge and advances once every third system clock. Each vertical sync rising edge stores the top four counter bits in one of two capture registers, and the two registers take turns. Because odd and even fields start half a line apart, the two stored phases differ. A magnitude compare of the two, with a polarity bit set by software, raises a start-field flag on the field where the display should begin.

Both sync inputs are asynchronous. Each one passes through a two-stage synchroniser and a rising-edge detector inside the block. All outputs are plain registered status levels. There is no data stream, so no valid/ready handshake exists and no back-pressure can occur. A downstream display controller samples the outputs whenever it needs them.

Top module: `field_parity_detector`

## Requirements
- R1: While reset is asserted and on the first cycle after it, both capture values, the status word, the next-target indicator and the start-field flag all read 0.
- R2: The line-phase counter returns to 0 on each synchronised horizontal sync rising edge and otherwise increments once every 3 system clocks.
- R3: The line-phase counter holds at 127 instead of wrapping, so a line with no horizontal sync captures the value 15.
- R4: Only a synchronised vertical sync rising edge captures; a held high level or a falling edge leaves both capture values and the next-target indicator unchanged.
- R5: Captures alternate between register A and register B, starting with A after reset; `next_is_b_o` is 1 exactly when the next capture will write register B.
- R6: `status_o` always equals {capture B, capture A}, with B in bits 7:4 and A in bits 3:0.
- R7: One cycle after each capture, the start-field flag takes the value (A > B) XOR `polarity_i`.
- R8: A change of `polarity_i` alone does not alter the flag until the next capture.
- R9: When horizontal and vertical sync rising edges are detected in the same cycle, the capture stores the counter value from before the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hsync_i | input | 1 | Horizontal sync, asynchronous, active high |
| vsync_i | input | 1 | Vertical sync, asynchronous, active high |
| polarity_i | input | 1 | Compare polarity select |
| cap_a_o | output | 4 | Phase captured into register A |
| cap_b_o | output | 4 | Phase captured into register B |
| status_o | output | 8 | {cap_b_o, cap_a_o} |
| next_is_b_o | output | 1 | The next capture writes register B |
| start_field_o | output | 1 | Display-start-field flag |

## Verification
Two functions can act in the same cycle: the line-phase counter clear and the phase capture. The bench triggers both by raising horizontal and vertical sync on the same cycle, so both edge detectors fire together. The capture must then hold the phase of the ending line, not zero. The behavioural reference model predicts this value, and the outputs are compared against the model every clock. A directed check tagged R9 also confirms that the stored value is non-zero.

// File: rtl/fpd_pkg.sv
package fpd_pkg;
  localparam int unsigned FPD_CNT_W    = 7;
  localparam int unsigned FPD_CAP_W    = 4;
  localparam int unsigned FPD_PRESCALE = 3;
  localparam int unsigned FPD_SYNC_N   = 2;

  typedef enum logic {
    TGT_A = 1'b0,
    TGT_B = 1'b1
  } fpd_target_e;
endpackage

// File: rtl/fpd_sync_edge.sv
module fpd_sync_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES-1:0] sh_q;
  logic              prev_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= async_i;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= {sh_q[STAGES-2:0], async_i};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sh_q[STAGES-1];
  end

  assign rise_o = sh_q[STAGES-1] & ~prev_q;

  assert_single_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);
endmodule

// File: rtl/fpd_line_phase.sv
module fpd_line_phase #(
  parameter int unsigned CNT_W    = 7,
  parameter int unsigned PRESCALE = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  output logic [CNT_W-1:0] count_o
);
  localparam int unsigned PRE_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic tick;
  logic [CNT_W-1:0] cnt_q;

  generate
    if (PRESCALE > 1) begin : g_div
      logic [PRE_W-1:0] pre_q;
      always_ff @(posedge clk) begin
        if (!rst_n || clr_i)                      pre_q <= '0;
        else if (pre_q == PRE_W'(PRESCALE - 1))   pre_q <= '0;
        else                                      pre_q <= pre_q + 1'b1;
      end
      assign tick = (pre_q == PRE_W'(PRESCALE - 1));
    end else begin : g_nodiv
      assign tick = 1'b1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n)                          cnt_q <= '0;
    else if (clr_i)                      cnt_q <= '0;
    else if (tick && cnt_q != CNT_MAX)   cnt_q <= cnt_q + 1'b1;
  end

  assign count_o = cnt_q;

  assert_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> count_o == '0);
  assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && count_o != CNT_MAX) |=>
      (count_o == $past(count_o) || count_o == $past(count_o) + 1'b1));
  assert_saturate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && count_o == CNT_MAX) |=> count_o == CNT_MAX);
endmodule

// File: rtl/fpd_field_capture.sv
module fpd_field_capture
  import fpd_pkg::*;
#(
  parameter int unsigned CNT_W = 7,
  parameter int unsigned CAP_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic             pol_i,
  output logic [CAP_W-1:0] cap_a_o,
  output logic [CAP_W-1:0] cap_b_o,
  output logic             next_b_o,
  output logic             flag_o
);
  fpd_target_e      tgt_q;
  logic [CAP_W-1:0] a_q, b_q;
  logic             done_q;
  logic             flag_q;
  logic [CAP_W-1:0] phase;

  assign phase = count_i[CNT_W-1 -: CAP_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tgt_q <= TGT_A;
      a_q   <= '0;
      b_q   <= '0;
    end else if (cap_i) begin
      if (tgt_q == TGT_A) begin
        a_q   <= phase;
        tgt_q <= TGT_B;
      end else begin
        b_q   <= phase;
        tgt_q <= TGT_A;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      done_q <= cap_i;
      if (done_q) flag_q <= (a_q > b_q) ^ pol_i;
    end
  end

  assign cap_a_o  = a_q;
  assign cap_b_o  = b_q;
  assign next_b_o = (tgt_q == TGT_B);
  assign flag_o   = flag_q;

  assert_alternate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cap_i |=> next_b_o != $past(next_b_o));
  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_i |=> ($stable(cap_a_o) && $stable(cap_b_o) && $stable(next_b_o)));
  assert_flag_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !done_q |=> $stable(flag_o));
  assert_one_written_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cap_i |=> (next_b_o ? $stable(cap_b_o) : $stable(cap_a_o)));
endmodule

// File: rtl/field_parity_detector.sv
module field_parity_detector
  import fpd_pkg::*;
#(
  parameter int unsigned CNT_W    = FPD_CNT_W,
  parameter int unsigned CAP_W    = FPD_CAP_W,
  parameter int unsigned PRESCALE = FPD_PRESCALE,
  parameter int unsigned SYNC_N   = FPD_SYNC_N
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               hsync_i,
  input  logic               vsync_i,
  input  logic               polarity_i,
  output logic [CAP_W-1:0]   cap_a_o,
  output logic [CAP_W-1:0]   cap_b_o,
  output logic [2*CAP_W-1:0] status_o,
  output logic               next_is_b_o,
  output logic               start_field_o
);
  logic             h_rise, v_rise;
  logic [CNT_W-1:0] phase_cnt;

  fpd_sync_edge #(.STAGES(SYNC_N)) u_hsync (
    .clk(clk), .rst_n(rst_n), .async_i(hsync_i), .rise_o(h_rise));

  fpd_sync_edge #(.STAGES(SYNC_N)) u_vsync (
    .clk(clk), .rst_n(rst_n), .async_i(vsync_i), .rise_o(v_rise));

  fpd_line_phase #(.CNT_W(CNT_W), .PRESCALE(PRESCALE)) u_phase (
    .clk(clk), .rst_n(rst_n), .clr_i(h_rise), .count_o(phase_cnt));

  fpd_field_capture #(.CNT_W(CNT_W), .CAP_W(CAP_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .cap_i(v_rise), .count_i(phase_cnt),
    .pol_i(polarity_i), .cap_a_o(cap_a_o), .cap_b_o(cap_b_o),
    .next_b_o(next_is_b_o), .flag_o(start_field_o));

  assign status_o = {cap_b_o, cap_a_o};

  assert_coincident_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (h_rise && v_rise && !next_is_b_o) |=>
      cap_a_o == $past(phase_cnt[CNT_W-1 -: CAP_W]));
endmodule

// File: tb/test_field_parity_detector.sv
module test_field_parity_detector;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hsync = 1'b0, vsync = 1'b0, pol = 1'b0;
  logic [3:0] cap_a, cap_b;
  logic [7:0] status;
  logic next_b, flag;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  field_parity_detector i_field_parity_detector (
    .clk(clk), .rst_n(rst_n), .hsync_i(hsync), .vsync_i(vsync),
    .polarity_i(pol), .cap_a_o(cap_a), .cap_b_o(cap_b), .status_o(status),
    .next_is_b_o(next_b), .start_field_o(flag));

  // behavioural reference model
  int m_h[3], m_v[3];
  int m_cnt, m_div, m_a, m_b, m_tog, m_flag, m_done;

  always @(posedge clk) begin
    int he, ve;
    if (!rst_n) begin
      m_h = '{0, 0, 0}; m_v = '{0, 0, 0};
      m_cnt = 0; m_div = 0; m_a = 0; m_b = 0; m_tog = 0; m_flag = 0; m_done = 0;
    end else begin
      he = (m_h[1] == 1 && m_h[2] == 0) ? 1 : 0;
      ve = (m_v[1] == 1 && m_v[2] == 0) ? 1 : 0;
      if (m_done == 1) m_flag = ((m_a > m_b) ? 1 : 0) ^ int'(pol);
      m_done = ve;
      if (ve == 1) begin
        if (m_tog == 0) m_a = m_cnt / 8; else m_b = m_cnt / 8;
        m_tog = 1 - m_tog;
      end
      if (he == 1) begin
        m_cnt = 0; m_div = 0;
      end else if (m_div == 2) begin
        m_div = 0;
        if (m_cnt < 127) m_cnt = m_cnt + 1;
      end else m_div = m_div + 1;
      m_h[2] = m_h[1]; m_h[1] = m_h[0]; m_h[0] = int'(hsync);
      m_v[2] = m_v[1]; m_v[1] = m_v[0]; m_v[0] = int'(vsync);
    end
  end

  task automatic check(string tag, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic compare_all();
    check("R5 cap_a", int'(cap_a), m_a);
    check("R5 cap_b", int'(cap_b), m_b);
    check("R5 next_is_b", int'(next_b), m_tog);
    check("R6 status", int'(status), m_b * 16 + m_a);
    check("R7 start_field", int'(flag), m_flag);
  endtask

  task automatic step(bit h, bit v, bit p);
    @(negedge clk);
    compare_all();
    hsync = h; vsync = v; pol = p;
  endtask

  // one line: hsync high for 2 clocks at start; vsync set to v_new at index v_at
  task automatic line(int len, int v_at, bit v_new);
    for (int i = 0; i < len; i++) begin
      if (i == v_at) vsync = v_new;
      step(i < 2, vsync, pol);
    end
  endtask

  task automatic settle(int n);
    for (int i = 0; i < n; i++) step(hsync, vsync, pol);
  endtask

  initial begin
    int saved_flag, tgt;
    repeat (3) @(negedge clk);
    check("R1 reset cap_a", int'(cap_a), 0);
    check("R1 reset status", int'(status), 0);
    check("R1 reset next", int'(next_b), 0);
    check("R1 reset flag", int'(flag), 0);
    @(negedge clk); rst_n = 1'b1;
    step(0, 0, 0);

    line(300, -1, 0);
    line(300, 200, 1);            // rise late in line -> A
    settle(2);
    check("R5 first capture A", int'(next_b), 1);
    check("R2 phase at 200", int'(cap_a), m_a);
    line(300, -1, 1);             // held high, no capture
    line(300, 100, 0);            // falling edge, no capture
    check("R4 no capture on level/fall", int'(next_b), 1);
    check("R4 cap_a unchanged", int'(cap_a), m_a);
    line(300, 30, 1);             // rise early -> B
    settle(3);
    check("R7 flag A>B pol0", int'(flag), 1);
    line(300, 50, 0);

    saved_flag = int'(flag);
    pol = 1'b1;
    settle(20);
    check("R8 polarity alone", int'(flag), saved_flag);
    line(300, 250, 1);            // -> A
    settle(3);
    check("R7 flag pol1", int'(flag), m_flag);
    line(300, 10, 0);

    // no hsync for long: saturation
    tgt = int'(next_b);
    for (int i = 0; i < 600; i++) step(0, 0, pol);
    step(0, 1, pol);
    settle(4);
    check("R3 saturated capture", tgt ? int'(cap_b) : int'(cap_a), 15);
    step(0, 0, pol);

    // coincident hsync and vsync rising edges
    for (int i = 0; i < 150; i++) step(0, 0, pol);
    tgt = int'(next_b);
    step(1, 1, pol);
    settle(4);
    check("R9 coincident captures pre-clear", tgt ? int'(cap_b) : int'(cap_a),
          tgt ? m_b : m_a);
    check("R9 capture non-zero", ((tgt ? int'(cap_b) : int'(cap_a)) != 0) ? 1 : 0, 1);
    step(0, 0, 0);
    line(300, -1, 0);
    line(300, 120, 1);
    line(300, 60, 0);
    line(300, 40, 1);
    settle(4);
    check("R6 final status", int'(status), int'(cap_b) * 16 + int'(cap_a));
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule